// File: doc/BRIEF.md
# System Control Port Register Bank

This block is a byte-wide register bank on a simple synchronous I/O bus. It decodes a small, fixed set of system control port addresses. It holds a handful of control bits, and these bits drive chip-level signals: a CPU reset request level, a little-endian mode flag, a contiguous I/O map select and an activity lamp. Writes to two dedicated ports send single-cycle toggle pulses to the lock logic of an external non-volatile memory.

Several ports return fixed identification and equipment values when read. Writes to those ports are discarded, except at the two lock ports, whose writes produce the pulses.

Reads are registered. The value for a read strobe appears on the read data bus in the following cycle and stays there until the next read strobe. The data always reflects the state as it was before any write in the same cycle.

Top module: `sysctl_port_bank`

## Requirements
- R1: A write to port 0x092 copies data bit 0 to `cpu_reset_o` (1 asserts, 0 releases) and data bit 1 to `little_endian_o`; both take effect in the cycle after the write strobe.
- R2: A read of port 0x092 returns the little-endian flag in bit 1 and zero in every other bit.
- R3: Reads of ports 0x800, 0x802 and 0x803 return 0xEF, 0xAD and 0xE0. Writes to these ports change no output and no readable value.
- R4: Reads of port 0x80C return 0x3C, port 0x810 returns 0x39, port 0x818 returns 0x00 and port 0x823 returns 0x03.
- R5: A write to port 0x810 raises `lock1_pulse_o`, and a write to port 0x812 raises `lock2_pulse_o`. The pulse is high for exactly the one cycle after the strobe, and the other pulse stays low.
- R6: Bit 0 of a write to port 0x808 sets (1) or clears (0) the lamp state, which drives `lamp_o` from the next cycle.
- R7: A write to port 0x81C stores data bits 3:0. A read of 0x81C returns the stored nibble in bits 3:0, with bits 7:4 zero.
- R8: Bit 0 of a write to port 0x850 sets or clears the contiguous-map flag. The flag drives `contig_map_o` and reads back in bit 0 of port 0x850, with all other bits zero.
- R9: Reads of any unmapped address, and of ports 0x808, 0x812 and 0x814, return 0xFF. Writes to any port that has no write function leave all outputs and stored state unchanged.
- R10: While `rst_n` is low, all stored bits are zero, `cpu_reset_o` is deasserted, both lock pulses are low and `bus_rdata` is 0x00.
- R11: The read data for a strobe appears in the cycle after the strobe and holds until the next strobe. When a read and a write reach the same port in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cpu_reset_o | output | 1 | CPU reset request level |
| little_endian_o | output | 1 | Little-endian mode flag |
| contig_map_o | output | 1 | Contiguous I/O map select |
| lamp_o | output | 1 | Activity lamp drive |
| lock1_pulse_o | output | 1 | Single-cycle toggle pulse for lock 1 |
| lock2_pulse_o | output | 1 | Single-cycle toggle pulse for lock 2 |

## Verification
A read and a write can reach the same port in one cycle. In that case the read must return the state from before the write, while the write still updates the state and the outputs. The bench provokes this by raising both strobes together on the system-control nibble port and on the endian/reset port. It checks that the returned byte equals the old stored value and that a later read shows the new one. A second collision is a read of port 0x810 together with a write to it. Here the bench expects the fixed ID byte on the bus and, in the same following cycle, a lock-1 pulse.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int PORT_W = 12;

  localparam logic [PORT_W-1:0] A_SPECIAL = 12'h092;
  localparam logic [PORT_W-1:0] A_CPUCFG  = 12'h800;
  localparam logic [PORT_W-1:0] A_FEAT    = 12'h802;
  localparam logic [PORT_W-1:0] A_STAT    = 12'h803;
  localparam logic [PORT_W-1:0] A_LAMP    = 12'h808;
  localparam logic [PORT_W-1:0] A_EQUIP   = 12'h80C;
  localparam logic [PORT_W-1:0] A_LOCK1   = 12'h810;
  localparam logic [PORT_W-1:0] A_LOCK2   = 12'h812;
  localparam logic [PORT_W-1:0] A_L2INV   = 12'h814;
  localparam logic [PORT_W-1:0] A_KEY     = 12'h818;
  localparam logic [PORT_W-1:0] A_SYSCTL  = 12'h81C;
  localparam logic [PORT_W-1:0] A_L2STAT  = 12'h823;
  localparam logic [PORT_W-1:0] A_MAP     = 12'h850;

  localparam logic [7:0] V_CPUCFG = 8'hEF;
  localparam logic [7:0] V_FEAT   = 8'hAD;
  localparam logic [7:0] V_STAT   = 8'hE0;
  localparam logic [7:0] V_EQUIP  = 8'h3C;
  localparam logic [7:0] V_XFEAT  = 8'h39;
  localparam logic [7:0] V_KEY    = 8'h00;
  localparam logic [7:0] V_L2STAT = 8'h03;
  localparam logic [7:0] V_UNMAP  = 8'hFF;

  localparam int SYSCTL_W = 4;

  typedef enum logic [3:0] {
    PT_NONE, PT_SPECIAL, PT_CPUCFG, PT_FEAT, PT_STAT, PT_LAMP, PT_EQUIP,
    PT_LOCK1, PT_LOCK2, PT_L2INV, PT_KEY, PT_SYSCTL, PT_L2STAT, PT_MAP
  } port_e;

  typedef struct packed {
    logic                cpu_rst;
    logic                endian;
    logic                lamp;
    logic [SYSCTL_W-1:0] sysctl;
    logic                cmap;
  } ctrl_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output port_e             port
);

  logic              upper_clear;
  logic [PORT_W-1:0] low_addr;

  generate
    if (ADDR_W > PORT_W) begin : g_wide
      assign upper_clear = ~|addr[ADDR_W-1:PORT_W];
      assign low_addr    = addr[PORT_W-1:0];
    end else begin : g_exact
      assign upper_clear = 1'b1;
      assign low_addr    = PORT_W'(addr);
    end
  endgenerate

  always_comb begin
    port = PT_NONE;
    if (upper_clear) begin
      case (low_addr)
        A_SPECIAL: port = PT_SPECIAL;
        A_CPUCFG:  port = PT_CPUCFG;
        A_FEAT:    port = PT_FEAT;
        A_STAT:    port = PT_STAT;
        A_LAMP:    port = PT_LAMP;
        A_EQUIP:   port = PT_EQUIP;
        A_LOCK1:   port = PT_LOCK1;
        A_LOCK2:   port = PT_LOCK2;
        A_L2INV:   port = PT_L2INV;
        A_KEY:     port = PT_KEY;
        A_SYSCTL:  port = PT_SYSCTL;
        A_L2STAT:  port = PT_L2STAT;
        A_MAP:     port = PT_MAP;
        default:   port = PT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_ctrl_regs.sv
module sysctl_ctrl_regs
  import sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  port_e      wr_port,
  input  logic [7:0] wdata,
  output ctrl_t      state,
  output logic       lock1_pulse,
  output logic       lock2_pulse
);

  ctrl_t state_q, state_d;
  logic  state_en;
  logic  lock1_d, lock2_d;
  logic  lock1_q, lock2_q;

  // Next state: only ports with a write function touch the stored bits.
  always_comb begin
    state_d  = state_q;
    state_en = 1'b0;
    if (wr_en) begin
      case (wr_port)
        PT_SPECIAL: begin
          state_d.cpu_rst = wdata[0];
          state_d.endian  = wdata[1];
          state_en        = 1'b1;
        end
        PT_LAMP: begin
          state_d.lamp = wdata[0];
          state_en     = 1'b1;
        end
        PT_SYSCTL: begin
          state_d.sysctl = wdata[SYSCTL_W-1:0];
          state_en       = 1'b1;
        end
        PT_MAP: begin
          state_d.cmap = wdata[0];
          state_en     = 1'b1;
        end
        default: begin
          state_en = 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    lock1_d = wr_en && (wr_port == PT_LOCK1);
    lock2_d = wr_en && (wr_port == PT_LOCK2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock1_q <= 1'b0;
      lock2_q <= 1'b0;
    end else begin
      lock1_q <= lock1_d;
      lock2_q <= lock2_d;
    end
  end

  assign state       = state_q;
  assign lock1_pulse = lock1_q;
  assign lock2_pulse = lock2_q;

endmodule

// File: rtl/sysctl_read_mux.sv
module sysctl_read_mux
  import sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  port_e      rd_port,
  input  ctrl_t      state,
  output logic [7:0] rdata
);

  logic [7:0] rd_d;
  logic [7:0] rd_q;

  always_comb begin
    case (rd_port)
      PT_SPECIAL: rd_d = {6'b0, state.endian, 1'b0};
      PT_CPUCFG:  rd_d = V_CPUCFG;
      PT_FEAT:    rd_d = V_FEAT;
      PT_STAT:    rd_d = V_STAT;
      PT_EQUIP:   rd_d = V_EQUIP;
      PT_LOCK1:   rd_d = V_XFEAT;
      PT_KEY:     rd_d = V_KEY;
      PT_SYSCTL:  rd_d = {{(8-SYSCTL_W){1'b0}}, state.sysctl};
      PT_L2STAT:  rd_d = V_L2STAT;
      PT_MAP:     rd_d = {7'b0, state.cmap};
      default:    rd_d = V_UNMAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 8'h00;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/sysctl_port_bank.sv
module sysctl_port_bank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              cpu_reset_o,
  output logic              little_endian_o,
  output logic              contig_map_o,
  output logic              lamp_o,
  output logic              lock1_pulse_o,
  output logic              lock2_pulse_o
);

  port_e sel_port;
  ctrl_t ctrl;

  sysctl_decode #(.ADDR_W(ADDR_W)) decode_i (
    .addr (bus_addr),
    .port (sel_port)
  );

  sysctl_ctrl_regs regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (bus_wr),
    .wr_port     (sel_port),
    .wdata       (bus_wdata),
    .state       (ctrl),
    .lock1_pulse (lock1_pulse_o),
    .lock2_pulse (lock2_pulse_o)
  );

  sysctl_read_mux rmux_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (bus_rd),
    .rd_port (sel_port),
    .state   (ctrl),
    .rdata   (bus_rdata)
  );

  assign cpu_reset_o     = ctrl.cpu_rst;
  assign little_endian_o = ctrl.endian;
  assign contig_map_o    = ctrl.cmap;
  assign lamp_o          = ctrl.lamp;

endmodule

// File: rtl/sysctl_port_bank_chk.sv
module sysctl_port_bank_chk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              cpu_reset_o,
  input logic              little_endian_o,
  input logic              contig_map_o,
  input logic              lamp_o,
  input logic              lock1_pulse_o,
  input logic              lock2_pulse_o
);

  logic hit_special, hit_lock1, hit_lock2, hit_map, hit_cpucfg;
  assign hit_special = (bus_addr == ADDR_W'(A_SPECIAL));
  assign hit_lock1   = (bus_addr == ADDR_W'(A_LOCK1));
  assign hit_lock2   = (bus_addr == ADDR_W'(A_LOCK2));
  assign hit_map     = (bus_addr == ADDR_W'(A_MAP));
  assign hit_cpucfg  = (bus_addr == ADDR_W'(A_CPUCFG));

  p_reset_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_special) |=> (cpu_reset_o == $past(bus_wdata[0])));

  p_endian_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_special) |=> (little_endian_o == $past(bus_wdata[1])));

  p_cpucfg_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_cpucfg) |=> (bus_rdata == V_CPUCFG));

  p_lock1_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_lock1) |=> lock1_pulse_o);

  p_lock1_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock1_pulse_o |-> ($past(bus_wr) && $past(hit_lock1)));

  p_lock2_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock2_pulse_o |-> ($past(bus_wr) && $past(hit_lock2)));

  p_lock_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock1_pulse_o, lock2_pulse_o}));

  p_map_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_map) |=> (contig_map_o == $past(bus_wdata[0])));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind sysctl_port_bank sysctl_port_bank_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_addr        (bus_addr),
  .bus_wr          (bus_wr),
  .bus_rd          (bus_rd),
  .bus_wdata       (bus_wdata),
  .bus_rdata       (bus_rdata),
  .cpu_reset_o     (cpu_reset_o),
  .little_endian_o (little_endian_o),
  .contig_map_o    (contig_map_o),
  .lamp_o          (lamp_o),
  .lock1_pulse_o   (lock1_pulse_o),
  .lock2_pulse_o   (lock2_pulse_o)
);

// File: tb/sysctl_port_bank_tb.sv
module sysctl_port_bank_tb_top;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        cpu_reset_o, little_endian_o, contig_map_o, lamp_o;
  logic        lock1_pulse_o, lock2_pulse_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Bench model of the writable state, kept from the requirements.
  logic       m_rst, m_end, m_lamp, m_map;
  logic [3:0] m_sys;

  sysctl_port_bank #(.ADDR_W(12)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wr          (bus_wr),
    .bus_rd          (bus_rd),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .cpu_reset_o     (cpu_reset_o),
    .little_endian_o (little_endian_o),
    .contig_map_o    (contig_map_o),
    .lamp_o          (lamp_o),
    .lock1_pulse_o   (lock1_pulse_o),
    .lock2_pulse_o   (lock2_pulse_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [11:0] a);
    case (a)
      12'h092: return {6'b0, m_end, 1'b0};
      12'h800: return 8'hEF;
      12'h802: return 8'hAD;
      12'h803: return 8'hE0;
      12'h80C: return 8'h3C;
      12'h810: return 8'h39;
      12'h818: return 8'h00;
      12'h81C: return {4'b0, m_sys};
      12'h823: return 8'h03;
      12'h850: return {7'b0, m_map};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk(req, {2'b0, lock2_pulse_o, lock1_pulse_o, lamp_o, contig_map_o, little_endian_o, cpu_reset_o},
        {4'b0, m_lamp, m_map, m_end, m_rst});
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      12'h092: begin m_rst = d[0]; m_end = d[1]; end
      12'h808: m_lamp = d[0];
      12'h81C: m_sys = d[3:0];
      12'h850: m_map = d[0];
      default: ;
    endcase
  endtask

  task automatic do_read(input logic [11:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic model_clear();
    m_rst = 0; m_end = 0; m_lamp = 0; m_map = 0; m_sys = 4'h0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] old;
    bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    model_clear();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rdata", bus_rdata, 8'h00);
    chk_outs("R10 outputs");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R7 R8 R9: read every address from reset state
    for (int a = 0; a < 4096; a++) begin
      do_read(12'(a), v);
      chk("R9 R3 R4 sweep read", v, exp_read(12'(a)));
    end

    // R1 R2: every bit-pair to the special port
    for (int d = 0; d < 4; d++) begin
      do_write(12'h092, 8'(d) | 8'hFC);
      chk_outs("R1 special write");
      do_read(12'h092, v);
      chk("R2 special readback", v, {6'b0, d[1], 1'b0});
    end
    do_write(12'h092, 8'h00);

    // R5: lock pulses last one cycle
    do_write(12'h810, 8'h00);
    chk("R5 lock1 high", {6'b0, lock2_pulse_o, lock1_pulse_o}, 8'h01);
    @(negedge clk);
    chk("R5 lock1 one cycle", {6'b0, lock2_pulse_o, lock1_pulse_o}, 8'h00);
    do_write(12'h812, 8'hFF);
    chk("R5 lock2 high", {6'b0, lock2_pulse_o, lock1_pulse_o}, 8'h02);
    @(negedge clk);
    chk("R5 lock2 one cycle", {6'b0, lock2_pulse_o, lock1_pulse_o}, 8'h00);

    // R6: lamp
    do_write(12'h808, 8'h01); chk_outs("R6 lamp on");
    do_write(12'h808, 8'hFE); chk_outs("R6 lamp off by bit0");
    do_write(12'h808, 8'h03); chk_outs("R6 lamp on again");

    // R7: every data value to the system-control port
    for (int d = 0; d < 256; d++) begin
      do_write(12'h81C, 8'(d));
      do_read(12'h81C, v);
      chk("R7 nibble readback", v, 8'(d & 15));
    end

    // R8: map flag
    do_write(12'h850, 8'h01); chk_outs("R8 map set");
    do_read(12'h850, v); chk("R8 map read", v, 8'h01);
    do_write(12'h850, 8'hFE); chk_outs("R8 map clear");
    do_read(12'h850, v); chk("R8 map read clear", v, 8'h00);
    do_write(12'h850, 8'h03);

    // R3 R9: writes to ports without a write function change nothing
    do_write(12'h092, 8'h02);
    do_write(12'h81C, 8'h0A);
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 4096; a++) begin
        if (a == 12'h092 || a == 12'h808 || a == 12'h81C || a == 12'h850 ||
            a == 12'h810 || a == 12'h812) continue;
        do_write(12'(a), (pass == 0) ? 8'h00 : 8'h01);
        chk_outs("R9 R3 ignored write");
      end
    end
    do_read(12'h81C, v); chk("R9 sysctl kept", v, 8'h0A);
    do_read(12'h092, v); chk("R9 endian kept", v, 8'h02);
    do_read(12'h800, v); chk("R3 id after write", v, 8'hEF);

    // R11: timing and hold
    do_read(12'h803, v);
    @(negedge clk);
    bus_addr = 12'h802; bus_rd = 1'b1;
    @(posedge clk); #1;
    chk("R11 rdata updates at edge", bus_rdata, 8'hAD);
    @(negedge clk); bus_rd = 1'b0;
    bus_addr = 12'h800;
    repeat (3) @(negedge clk);
    chk("R11 rdata held", bus_rdata, 8'hAD);

    // R11: read and write on the same port in one cycle
    old = {4'b0, m_sys};
    @(negedge clk);
    bus_addr = 12'h81C; bus_wdata = 8'h35; bus_rd = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; m_sys = 4'h5;
    chk("R11 collide sysctl old", bus_rdata, old);
    do_read(12'h81C, v); chk("R11 collide sysctl new", v, 8'h05);

    @(negedge clk);
    bus_addr = 12'h092; bus_wdata = 8'h01; bus_rd = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; m_rst = 1'b1; m_end = 1'b0;
    chk("R11 collide special old", bus_rdata, 8'h02);
    chk_outs("R1 collide special outputs");

    @(negedge clk);
    bus_addr = 12'h810; bus_rd = 1'b1; bus_wr = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R4 collide lock read", bus_rdata, 8'h39);
    chk("R5 collide lock pulse", {7'b0, lock1_pulse_o}, 8'h01);

    // R10: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    model_clear();
    chk("R10 rdata after reset", bus_rdata, 8'h00);
    chk_outs("R10 outputs after reset");
    rst_n = 1'b1;
    do_read(12'h81C, v); chk("R10 sysctl cleared", v, 8'h00);

    done = 1;
    finish_run();
  end

endmodule